// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synchronous single-port memory built for back-to-back traffic. On every rising clock edge it samples three chip selects, an advance/load strobe and a read/write select. From these it either registers a fresh address and direction, steps a 2-bit burst counter inside the current burst, or starts a deselect. For every access, reads and writes alike, the data phase falls exactly two clock edges after the command edge. Because of this, a read may follow a write (or the reverse) in the very next cycle with no idle slot on the data bus.

The bidirectional data bus is split into an input word, an output word and a drive flag. A static strap chooses between two orders for the two low address bits within a burst: the linear order counts up modulo 4, and the interleaved order XORs the start offset with the beat number. Two inputs can release the bus at any moment, independently of the clock: an output-enable input and a sleep input. Sleep also drops every command that is still in flight and keeps the stored contents.

Top module: `ztpipe_sram`

## Requirements
- R1: A write is loaded when `adv`=0 and all selects are asserted (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) with `rd_wr_n`=0. The word on `dq_in` at the second rising edge after the load edge is stored at the loaded address.
- R2: A read loaded at edge E sets `dq_drive`=1 and presents the stored word on `dq_out` from edge E+2 until edge E+3. Before E+2 the read does not drive the bus. A write's data phase never drives the bus.
- R3: A new load may be issued on every edge, alternating read and write with no idle cycle. A read issued one cycle after a write to the same address returns the newly written word.
- R4: With `burst_ilv`=0, each `adv`=1 edge inside a burst steps the two low address bits as start+k modulo 4 (k = beats since the load). The upper address bits keep their loaded value.
- R5: With `burst_ilv`=1, the two low address bits of beat k are start XOR k.
- R6: On an `adv`=1 edge, `addr` and `rd_wr_n` are ignored. Every beat keeps the direction captured at the load.
- R7: A load edge (`adv`=0) with any one select deasserted is a deselect. Its data slot two edges later leaves `dq_drive`=0. Later `adv`=1 edges start no access until a new selected load.
- R8: `oe_n`=1 holds `dq_drive` at 0 independently of the clock. Lowering `oe_n` during a read data slot shows the read word at once.
- R9: `sleep`=1 forces `dq_drive` to 0 at once. Edges sampled while it is high accept no command and cancel in-flight accesses. Stored words are kept, and the first selected load after `sleep` falls works normally.
- R10: While `rst_n`=0 and after its release, `dq_drive`=0 and `dq_out`=0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control pipeline |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance the burst, 0 = load a new command |
| rd_wr_n | input | 1 | 1 = read, 0 = write; sampled on load edges |
| addr | input | ADDR_W | Word address; sampled on load edges |
| burst_ilv | input | 1 | Static strap: 1 = interleaved, 0 = linear burst order |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Standby request, active high |
| dq_in | input | DATA_W | Write data, sampled two edges after its command |
| dq_out | output | DATA_W | Registered read data |
| dq_drive | output | 1 | 1 while the block drives the data bus |

## Verification
The bench runs a write, then a read, then a write, then a read to neighbouring addresses on consecutive edges. A design with a one-cycle read path, or with a write that lands a cycle late, would return the stale word or shift the data by one slot. Burst tests start at offset 1 in both orders, so the two orders produce different address sequences. During those bursts the bench drives a garbage address and the opposite direction on the advance cycles, which exposes a counter that wraps wrongly, picks the wrong order, or re-samples those inputs. It also exercises deselect through each select in turn, output enable and sleep both in the middle of a data slot, and a write attempted during sleep. A design that ignored any of these would drive the bus when it should be released or would overwrite a kept word.

// File: rtl/ztp_pkg.sv
`timescale 1ns/1ps
package ztp_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

   // width of the burst offset field in the address
   localparam int unsigned BURST_W = 2;

   // low address bits for beat 'step' of a burst that started at 'start'
   function automatic logic [BURST_W-1:0] burst_offset(
      input logic [BURST_W-1:0] start,
      input logic [BURST_W-1:0] step,
      input logic               ilv
   );
      return ilv ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/ztp_mem_array.sv
`timescale 1ns/1ps
module ztp_mem_array #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 18,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end

   // one storage array per byte lane
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[addr];
   end

endmodule

// File: rtl/ztp_burst_gen.sv
`timescale 1ns/1ps
module ztp_burst_gen
   import ztp_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              adv,
   input  logic              selected,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_read,
   input  logic              ilv,
   output op_e               cur_op,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int unsigned HI_W = ADDR_W - BURST_W;

   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("ADDR_W must exceed the burst field width");
   end

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] step_q;
   op_e                dir_q;   // direction of the open burst, IDLE if none
   op_e                op_q;    // command for the current beat

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         step_q <= '0;
         dir_q  <= OP_IDLE;
         op_q   <= OP_IDLE;
      end else if (flush) begin
         dir_q <= OP_IDLE;
         op_q  <= OP_IDLE;
      end else if (!adv) begin
         if (selected) begin
            base_q <= ld_addr;
            step_q <= '0;
            dir_q  <= ld_read ? OP_RD : OP_WR;
            op_q   <= ld_read ? OP_RD : OP_WR;
         end else begin
            dir_q <= OP_IDLE;
            op_q  <= OP_IDLE;
         end
      end else if (dir_q != OP_IDLE) begin
         step_q <= step_q + 1'b1;
         op_q   <= dir_q;
      end else begin
         op_q <= OP_IDLE;
      end
   end

   assign cur_op   = op_q;
   assign cur_addr = {base_q[ADDR_W-1 -: HI_W],
                      burst_offset(base_q[BURST_W-1:0], step_q, ilv)};

   assert_lin_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !flush && dir_q != OP_IDLE && !ilv
      |=> cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + 2'd1);

   assert_ilv_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !flush && dir_q != OP_IDLE && ilv && step_q == '0
      |=> cur_addr[BURST_W-1:0] == ($past(cur_addr[BURST_W-1:0]) ^ 2'd1));

   assert_hold_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !flush && dir_q != OP_IDLE
      |=> $stable(cur_addr[ADDR_W-1:BURST_W]) && cur_op == $past(dir_q));

   assert_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !adv && !selected && !flush |=> cur_op == OP_IDLE);

endmodule

// File: rtl/ztp_data_pipe.sv
`timescale 1ns/1ps
module ztp_data_pipe
   import ztp_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  op_e               in_op,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              launch_q,
   output logic [DATA_W-1:0] rd_q
);
   op_e               op2_q;
   logic [ADDR_W-1:0] addr2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op2_q    <= OP_IDLE;
         addr2_q  <= '0;
         launch_q <= 1'b0;
         rd_q     <= '0;
      end else if (flush) begin
         op2_q    <= OP_IDLE;
         launch_q <= 1'b0;
      end else begin
         op2_q    <= in_op;
         addr2_q  <= in_addr;
         launch_q <= (op2_q == OP_RD);
         if (op2_q == OP_RD) rd_q <= mem_rdata;
      end
   end

   // data phase: the write lands on the same edge a read would launch
   assign mem_we   = (op2_q == OP_WR) && !flush;
   assign mem_addr = addr2_q;

   assert_rd_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op2_q == OP_RD && !flush |=> launch_q);

   assert_wr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op2_q == OP_WR |=> !launch_q);

   assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> op2_q == OP_IDLE && !launch_q);

endmodule

// File: rtl/ztpipe_sram.sv
`timescale 1ns/1ps
module ztpipe_sram
   import ztp_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 18,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              adv,
   input  logic              rd_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_ilv,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drive
);
   logic              selected;
   op_e               beat_op;
   logic [ADDR_W-1:0] beat_addr;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_rdata;
   logic              launch_q;

   assign selected = !sel_a_n && sel_b && !sel_c_n;

   ztp_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (sleep),
      .adv      (adv),
      .selected (selected),
      .ld_addr  (addr),
      .ld_read  (rd_wr_n),
      .ilv      (burst_ilv),
      .cur_op   (beat_op),
      .cur_addr (beat_addr)
   );

   ztp_data_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (sleep),
      .in_op     (beat_op),
      .in_addr   (beat_addr),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .launch_q  (launch_q),
      .rd_q      (dq_out)
   );

   ztp_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (dq_in),
      .rdata (mem_rdata)
   );

   // bus release from output enable and sleep is not clocked
   assign dq_drive = launch_q && !oe_n && !sleep;

   assert_sleep_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !launch_q && beat_op == OP_IDLE);

   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> !launch_q);

endmodule

// File: tb/test_ztpipe_sram.sv
`timescale 1ns/1ps
module test_ztpipe_sram;
   localparam logic [2:0] SEL = 3'b010;   // {sel_a_n, sel_b, sel_c_n}

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic        adv = 1'b0, rd_wr_n = 1'b1;
   logic [5:0]  addr = '0;
   logic        burst_ilv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
   logic [17:0] dq_in = '0;
   logic [17:0] dq_out;
   logic        dq_drive;
   int          nchk = 0, nfail = 0;

   always #10 clk = ~clk;

   ztpipe_sram i_ztpipe_sram (
      .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .adv(adv), .rd_wr_n(rd_wr_n), .addr(addr),
      .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in),
      .dq_out(dq_out), .dq_drive(dq_drive)
   );

   // one clock: drive inputs now, return at the following falling edge
   task automatic cyc(input logic [2:0] en, input logic a_dv, input logic rw,
                      input logic [5:0] a, input logic [17:0] d);
      {sel_a_n, sel_b, sel_c_n} = en;
      adv = a_dv; rd_wr_n = rw; addr = a; dq_in = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ld_w(input logic [5:0] a, input logic [17:0] d); cyc(SEL, 1'b0, 1'b0, a, d); endtask
   task automatic ld_r(input logic [5:0] a, input logic [17:0] d); cyc(SEL, 1'b0, 1'b1, a, d); endtask
   task automatic stp(input logic rw, input logic [17:0] d);       cyc(SEL, 1'b1, rw, 6'h3F, d); endtask
   task automatic idle(input logic [17:0] d);                      cyc(3'b110, 1'b0, 1'b1, 6'h00, d); endtask

   task automatic chk(input string req, input logic exp_drv,
                      input logic [17:0] exp_out, input bit cmp);
      nchk++;
      if (dq_drive !== exp_drv || (cmp && dq_out !== exp_out)) begin
         nfail++;
         $display("FAIL %s: drive=%0b out=%h expected drive=%0b out=%h",
                  req, dq_drive, dq_out, exp_drv, exp_out);
      end
   endtask

   task automatic t_reset_r10();
      repeat (3) @(negedge clk);
      chk("R10 in reset", 1'b0, 18'h0, 1);
      rst_n = 1'b1;
      idle(0);
      chk("R10 after reset", 1'b0, 18'h0, 1);
   endtask

   task automatic t_single_r1_r2();
      ld_w(6'd5, 0); idle(0); idle(18'h2A5A5);
      chk("R2 write slot quiet", 1'b0, 0, 0);
      ld_r(6'd5, 0); idle(0);
      chk("R2 no early data", 1'b0, 0, 0);
      idle(0);
      chk("R1 R2 read data", 1'b1, 18'h2A5A5, 1);
      idle(0);
      chk("R2 one slot only", 1'b0, 0, 0);
   endtask

   task automatic t_linear_r4_r6();
      burst_ilv = 1'b0;
      ld_w(6'd9, 0); stp(1'b1, 0); stp(1'b1, 18'h00D0); stp(1'b1, 18'h00D1);
      idle(18'h00D2); idle(18'h00D3);
      ld_r(6'd9, 0); ld_r(6'd10, 0);
      ld_r(6'd11, 0); chk("R4 R6 addr 9", 1'b1, 18'h00D0, 1);
      ld_r(6'd8, 0);  chk("R4 addr 10", 1'b1, 18'h00D1, 1);
      idle(0);        chk("R4 addr 11", 1'b1, 18'h00D2, 1);
      idle(0);        chk("R4 wrap addr 8", 1'b1, 18'h00D3, 1);
      // burst read while advance cycles present write direction
      ld_r(6'd9, 0); stp(1'b0, 18'h3FFFF);
      stp(1'b0, 18'h3FFFF); chk("R6 beat0", 1'b1, 18'h00D0, 1);
      stp(1'b0, 18'h3FFFF); chk("R6 beat1", 1'b1, 18'h00D1, 1);
      idle(0);              chk("R4 beat2", 1'b1, 18'h00D2, 1);
      idle(0);              chk("R4 beat3", 1'b1, 18'h00D3, 1);
   endtask

   task automatic t_ilv_r5();
      burst_ilv = 1'b1;
      ld_w(6'd16, 0); ld_w(6'd17, 0);
      ld_w(6'd18, 18'h1E010); ld_w(6'd19, 18'h1E011);
      idle(18'h1E012); idle(18'h1E013);
      ld_r(6'd17, 0); stp(1'b0, 0);
      stp(1'b0, 0); chk("R5 beat0 17", 1'b1, 18'h1E011, 1);
      stp(1'b0, 0); chk("R5 beat1 16", 1'b1, 18'h1E010, 1);
      idle(0);      chk("R5 beat2 19", 1'b1, 18'h1E013, 1);
      idle(0);      chk("R5 beat3 18", 1'b1, 18'h1E012, 1);
      burst_ilv = 1'b0;
      idle(0);
   endtask

   task automatic t_turn_r3();
      ld_w(6'd20, 0); ld_r(6'd20, 0);
      ld_w(6'd21, 18'h12020);
      ld_r(6'd21, 0);       chk("R3 read after write", 1'b1, 18'h12020, 1);
      idle(18'h12121);      chk("R3 write slot quiet", 1'b0, 0, 0);
      idle(0);              chk("R3 second read", 1'b1, 18'h12121, 1);
   endtask

   task automatic t_desel_r7();
      for (int k = 0; k < 3; k++) begin
         logic [2:0] off;
         off = (k == 0) ? 3'b110 : (k == 1) ? 3'b000 : 3'b011;
         ld_r(6'd5, 0);
         cyc(off, 1'b0, 1'b1, 6'd9, 0);
         stp(1'b1, 0); chk("R7 read before deselect", 1'b1, 18'h2A5A5, 1);
         idle(0);      chk("R7 deselect slot", 1'b0, 0, 0);
         idle(0);      chk("R7 advance after deselect", 1'b0, 0, 0);
      end
   endtask

   task automatic t_oe_r8();
      oe_n = 1'b1;
      ld_r(6'd5, 0); idle(0); idle(0);
      chk("R8 oe high", 1'b0, 0, 0);
      #2 oe_n = 1'b0;
      #1 chk("R8 oe low mid slot", 1'b1, 18'h2A5A5, 1);
      idle(0);
   endtask

   task automatic t_sleep_r9();
      ld_r(6'd5, 0);
      sleep = 1'b1;
      ld_w(6'd5, 0);        chk("R9 sleep", 1'b0, 0, 0);
      idle(18'h01111);      chk("R9 in-flight dropped", 1'b0, 0, 0);
      sleep = 1'b0;
      idle(18'h01111);      chk("R9 after sleep", 1'b0, 0, 0);
      ld_r(6'd5, 0); idle(0); idle(0);
      chk("R9 contents kept", 1'b1, 18'h2A5A5, 1);
      #2 sleep = 1'b1;
      #1 chk("R9 immediate release", 1'b0, 0, 0);
      sleep = 1'b0;
      idle(0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      nchk++; nfail++;
      $display("FAIL watchdog: drive=%0b out=%h expected run to end", dq_drive, dq_out);
      summary();
   end

   initial begin
      @(negedge clk);
      t_reset_r10();
      t_single_r1_r2();
      t_linear_r4_r6();
      t_ilv_r5();
      t_turn_r3();
      t_desel_r7();
      t_oe_r8();
      t_sleep_r9();
      summary();
   end

endmodule